// File: doc/BRIEF.md
# Byte Alignment Data Unit

This unit carries out two related operations for unaligned 64-bit data handling, built around a small status register that holds a byte offset. The address-align operation adds two 64-bit operands. It returns the sum rounded down to an 8-byte boundary and keeps the three discarded low bits as the byte offset in the status register. The aligned-data operation then uses that stored offset to pull one 64-bit word out of a pair of adjacent 64-bit words. It does this as a two-word funnel shift.

A decoded operation code and a valid strobe start each operation, and the result comes back one cycle later with its own valid strobe. Software can read and write the status register through an auxiliary-register port, as register number 0x13. While the floating-point enable input is low, every operation and every access to the status register is refused, and the unit raises a disabled-unit trap instead.

Top module: `byte_align_unit`

## Requirements
- R1: When an operation with code 0x018 is accepted, the next cycle shows `res_valid_o` high for exactly one cycle. `res_data_o` then equals (src_a + src_b) modulo 2^64 with bits [2:0] cleared.
- R2: An accepted 0x018 operation copies bits [2:0] of the sum into status bits [2:0] and leaves status bits [63:3] unchanged.
- R3: An accepted operation with code 0x048 returns (src_a << 8k) | (src_b >> (64 - 8k)) one cycle later, where k is status bits [2:0]. Status bits [63:3] have no effect on the result.
- R4: When k is zero, the 0x048 result equals src_a exactly. src_b does not leak in through a wrapped shift.
- R5: Code 0x01a is accepted without any effect: no result, no trap, and the status register is unchanged.
- R6: Any other operation code raises `trap_ill_o` for one cycle. It produces no result and leaves the status register unchanged.
- R7: While `fpu_en_i` is low, an operation or an auxiliary access to register 0x13 raises `trap_fpu_o` for one cycle. In that case there is no result, no read response and no change to the status register.
- R8: An auxiliary read of register 0x13 sets `aux_rvalid_o` for one cycle on the next cycle. `aux_rdata_o` then holds the status value as it was before that edge. An auxiliary write to register 0x13 replaces all 64 status bits.
- R9: When an auxiliary write to 0x13 and an accepted 0x018 operation fall in the same cycle, the status register takes the written value. The 0x018 result is still returned.
- R10: Auxiliary reads and writes to any register number other than 0x13 are ignored: there is no read response and no status change.
- R11: After reset, all outputs are low or zero and the status register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 9 | Decoded operation code |
| src_a_i | input | 64 | First operand |
| src_b_i | input | 64 | Second operand |
| fpu_en_i | input | 1 | Floating-point unit enabled |
| aux_rd_i | input | 1 | Auxiliary register read strobe |
| aux_wr_i | input | 1 | Auxiliary register write strobe |
| aux_num_i | input | 5 | Auxiliary register number |
| aux_wdata_i | input | 64 | Auxiliary write data |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 64 | Operation result |
| aux_rvalid_o | output | 1 | Auxiliary read response strobe |
| aux_rdata_o | output | 64 | Auxiliary read data |
| trap_fpu_o | output | 1 | Disabled-unit trap pulse |
| trap_ill_o | output | 1 | Illegal-code trap pulse |

## Verification
The offset update from an address-align operation and an explicit auxiliary write to the status register can land on the same clock edge. The bench provokes this by driving a 0x018 operation whose sum has nonzero low bits in the same cycle as a write of a distinctive 64-bit pattern. It then reads the register back and expects the written pattern untouched, while the align result of that cycle must still come out correctly. A second overlap, a read and a write to the status register in the same cycle, is judged by expecting the read to return the value from before the write.

// File: rtl/bau_pkg.sv
package bau_pkg;

   typedef enum logic [2:0] {
      OPK_NONE,
      OPK_ALIGN,
      OPK_ALIGN_LE,
      OPK_FALIGN,
      OPK_ILLEGAL
   } op_kind_e;

   typedef struct packed {
      logic do_align;
      logic do_falign;
      logic ill;
      logic fpu_trap;
      logic gsr_rd;
      logic gsr_wr;
   } dec_t;

endpackage

// File: rtl/bau_decode.sv
module bau_decode
   import bau_pkg::*;
#(
   parameter int                OPC_W        = 9,
   parameter int                AUX_W        = 5,
   parameter logic [OPC_W-1:0]  OPC_ALIGN    = 9'h018,
   parameter logic [OPC_W-1:0]  OPC_ALIGN_LE = 9'h01a,
   parameter logic [OPC_W-1:0]  OPC_FALIGN   = 9'h048,
   parameter logic [AUX_W-1:0]  AUX_GSR      = 5'h13
) (
   input  logic             op_valid,
   input  logic [OPC_W-1:0] op_code,
   input  logic             fpu_en,
   input  logic             aux_rd,
   input  logic             aux_wr,
   input  logic [AUX_W-1:0] aux_num,
   output dec_t             dec
);

   op_kind_e kind;
   logic     gsr_sel;

   always_comb begin
      case (op_code)
         OPC_ALIGN:    kind = OPK_ALIGN;
         OPC_ALIGN_LE: kind = OPK_ALIGN_LE;
         OPC_FALIGN:   kind = OPK_FALIGN;
         default:      kind = OPK_ILLEGAL;
      endcase
      if (!op_valid) kind = OPK_NONE;
   end

   assign gsr_sel = (aux_num == AUX_GSR);

   always_comb begin
      dec = '0;
      if (!fpu_en) begin
         dec.fpu_trap = op_valid | (gsr_sel & (aux_rd | aux_wr));
      end else begin
         dec.gsr_rd = gsr_sel & aux_rd;
         dec.gsr_wr = gsr_sel & aux_wr;
         unique case (kind)
            OPK_ALIGN:   dec.do_align  = 1'b1;
            OPK_FALIGN:  dec.do_falign = 1'b1;
            OPK_ILLEGAL: dec.ill       = 1'b1;
            default:     ;
         endcase
      end
   end

endmodule

// File: rtl/bau_addr_align.sv
module bau_addr_align #(
   parameter int DATA_W = 64,
   parameter int OFF_W  = 3
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] aligned,
   output logic [OFF_W-1:0]  off
);

   logic [DATA_W-1:0] sum;

   assign sum     = a + b;
   assign aligned = {sum[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
   assign off     = sum[OFF_W-1:0];

endmodule

// File: rtl/bau_funnel.sv
module bau_funnel #(
   parameter int DATA_W      = 64,
   parameter int OFF_W       = 3,
   parameter int SHIFT_STYLE = 0
) (
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] lo,
   input  logic [OFF_W-1:0]  off,
   output logic [DATA_W-1:0] y
);

   localparam int NBYTES = 1 << OFF_W;
   localparam int BYTE_W = DATA_W / NBYTES;

   generate
      if (SHIFT_STYLE == 0) begin : g_mux
         logic [DATA_W-1:0] cand [NBYTES];
         for (genvar k = 0; k < NBYTES; k++) begin : g_cand
            if (k == 0) begin : g_zero
               assign cand[k] = hi;
            end else begin : g_shift
               assign cand[k] = {hi[DATA_W-1-k*BYTE_W:0], lo[DATA_W-1 -: k*BYTE_W]};
            end
         end
         assign y = cand[off];
      end else begin : g_wide
         logic [2*DATA_W-1:0] cat;
         assign cat = {hi, lo} << (32'(off) * BYTE_W);
         assign y   = cat[2*DATA_W-1:DATA_W];
      end
   endgenerate

endmodule

// File: rtl/bau_gsr_reg.sv
module bau_gsr_reg #(
   parameter int GSR_W = 64,
   parameter int OFF_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [GSR_W-1:0] wr_data,
   input  logic             upd_en,
   input  logic [OFF_W-1:0] upd_off,
   output logic [GSR_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wr_data;
      end else if (upd_en) begin
         q[OFF_W-1:0] <= upd_off;
      end
   end

endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit
   import bau_pkg::*;
#(
   parameter int                DATA_W       = 64,
   parameter int                GSR_W        = 64,
   parameter int                OPC_W        = 9,
   parameter int                AUX_W        = 5,
   parameter logic [OPC_W-1:0]  OPC_ALIGN    = 9'h018,
   parameter logic [OPC_W-1:0]  OPC_ALIGN_LE = 9'h01a,
   parameter logic [OPC_W-1:0]  OPC_FALIGN   = 9'h048,
   parameter logic [AUX_W-1:0]  AUX_GSR      = 5'h13,
   parameter int                SHIFT_STYLE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid_i,
   input  logic [OPC_W-1:0]  op_code_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic              fpu_en_i,
   input  logic              aux_rd_i,
   input  logic              aux_wr_i,
   input  logic [AUX_W-1:0]  aux_num_i,
   input  logic [GSR_W-1:0]  aux_wdata_i,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_data_o,
   output logic              aux_rvalid_o,
   output logic [GSR_W-1:0]  aux_rdata_o,
   output logic              trap_fpu_o,
   output logic              trap_ill_o
);

   localparam int NBYTES = DATA_W / 8;
   localparam int OFF_W  = $clog2(NBYTES);

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("byte_align_unit: DATA_W must be a whole number of bytes");
      end
      if ((1 << OFF_W) != NBYTES) begin : g_bad_pow2
         $error("byte_align_unit: DATA_W/8 must be a power of two");
      end
      if (GSR_W < OFF_W) begin : g_bad_gsr
         $error("byte_align_unit: GSR_W too narrow for the byte offset");
      end
      if (SHIFT_STYLE != 0 && SHIFT_STYLE != 1) begin : g_bad_style
         $error("byte_align_unit: SHIFT_STYLE must be 0 or 1");
      end
   endgenerate

   dec_t              dec;
   logic [GSR_W-1:0]  gsr_q;
   logic [DATA_W-1:0] align_res;
   logic [OFF_W-1:0]  align_off;
   logic [DATA_W-1:0] fal_res;
   logic [DATA_W-1:0] res_next;

   bau_decode #(
      .OPC_W        (OPC_W),
      .AUX_W        (AUX_W),
      .OPC_ALIGN    (OPC_ALIGN),
      .OPC_ALIGN_LE (OPC_ALIGN_LE),
      .OPC_FALIGN   (OPC_FALIGN),
      .AUX_GSR      (AUX_GSR)
   ) u_dec (
      .op_valid (op_valid_i),
      .op_code  (op_code_i),
      .fpu_en   (fpu_en_i),
      .aux_rd   (aux_rd_i),
      .aux_wr   (aux_wr_i),
      .aux_num  (aux_num_i),
      .dec      (dec)
   );

   bau_addr_align #(
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W)
   ) u_addr (
      .a       (src_a_i),
      .b       (src_b_i),
      .aligned (align_res),
      .off     (align_off)
   );

   bau_funnel #(
      .DATA_W      (DATA_W),
      .OFF_W       (OFF_W),
      .SHIFT_STYLE (SHIFT_STYLE)
   ) u_fun (
      .hi  (src_a_i),
      .lo  (src_b_i),
      .off (gsr_q[OFF_W-1:0]),
      .y   (fal_res)
   );

   bau_gsr_reg #(
      .GSR_W (GSR_W),
      .OFF_W (OFF_W)
   ) u_gsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dec.gsr_wr),
      .wr_data (aux_wdata_i),
      .upd_en  (dec.do_align),
      .upd_off (align_off),
      .q       (gsr_q)
   );

   assign res_next = dec.do_align ? align_res : fal_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_o  <= 1'b0;
         res_data_o   <= '0;
         aux_rvalid_o <= 1'b0;
         aux_rdata_o  <= '0;
         trap_fpu_o   <= 1'b0;
         trap_ill_o   <= 1'b0;
      end else begin
         res_valid_o  <= dec.do_align | dec.do_falign;
         aux_rvalid_o <= dec.gsr_rd;
         trap_fpu_o   <= dec.fpu_trap;
         trap_ill_o   <= dec.ill;
         if (dec.do_align | dec.do_falign) res_data_o  <= res_next;
         if (dec.gsr_rd)                   aux_rdata_o <= gsr_q;
      end
   end

endmodule

// File: rtl/bau_checker.sv
module bau_checker #(
   parameter int                DATA_W       = 64,
   parameter int                GSR_W        = 64,
   parameter int                OPC_W        = 9,
   parameter int                AUX_W        = 5,
   parameter logic [OPC_W-1:0]  OPC_ALIGN    = 9'h018,
   parameter logic [OPC_W-1:0]  OPC_ALIGN_LE = 9'h01a,
   parameter logic [OPC_W-1:0]  OPC_FALIGN   = 9'h048,
   parameter logic [AUX_W-1:0]  AUX_GSR      = 5'h13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid_i,
   input logic [OPC_W-1:0]  op_code_i,
   input logic [DATA_W-1:0] src_a_i,
   input logic [DATA_W-1:0] src_b_i,
   input logic              fpu_en_i,
   input logic              aux_rd_i,
   input logic              aux_wr_i,
   input logic [AUX_W-1:0]  aux_num_i,
   input logic [GSR_W-1:0]  aux_wdata_i,
   input logic              res_valid_o,
   input logic [DATA_W-1:0] res_data_o,
   input logic              aux_rvalid_o,
   input logic [GSR_W-1:0]  aux_rdata_o,
   input logic              trap_fpu_o,
   input logic              trap_ill_o,
   input logic [GSR_W-1:0]  gsr_q
);

   localparam int OFF_W = $clog2(DATA_W / 8);

   logic acc_op, code_legal, gsr_acc;
   assign acc_op     = op_valid_i && fpu_en_i;
   assign code_legal = (op_code_i == OPC_ALIGN) || (op_code_i == OPC_ALIGN_LE) ||
                       (op_code_i == OPC_FALIGN);
   assign gsr_acc    = aux_num_i == AUX_GSR;

   AST_ALIGN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      acc_op && op_code_i == OPC_ALIGN |=> res_valid_o &&
      res_data_o == (($past(src_a_i) + $past(src_b_i)) & ~DATA_W'((1 << OFF_W) - 1))); // R1

   AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_op && (op_code_i == OPC_ALIGN || op_code_i == OPC_FALIGN)) |=> !res_valid_o); // R5

   AST_ILLEGAL_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      acc_op && !code_legal |=> trap_ill_o && !res_valid_o); // R6

   AST_NO_FALSE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_op && !code_legal) |=> !trap_ill_o); // R6

   AST_FPU_OFF_OP: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid_i && !fpu_en_i |=> trap_fpu_o && !res_valid_o); // R7

   AST_FPU_OFF_GSR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !fpu_en_i |=> $stable(gsr_q)); // R7

   AST_AUX_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      aux_rd_i && fpu_en_i && gsr_acc |=> aux_rvalid_o && aux_rdata_o == $past(gsr_q)); // R8

   AST_AUX_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      aux_wr_i && fpu_en_i && gsr_acc |=> gsr_q == $past(aux_wdata_i)); // R9

   AST_OTHER_AUX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !(aux_rd_i && fpu_en_i && gsr_acc) |=> !aux_rvalid_o); // R10

endmodule

bind byte_align_unit bau_checker #(
   .DATA_W       (DATA_W),
   .GSR_W        (GSR_W),
   .OPC_W        (OPC_W),
   .AUX_W        (AUX_W),
   .OPC_ALIGN    (OPC_ALIGN),
   .OPC_ALIGN_LE (OPC_ALIGN_LE),
   .OPC_FALIGN   (OPC_FALIGN),
   .AUX_GSR      (AUX_GSR)
) u_bau_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid_i   (op_valid_i),
   .op_code_i    (op_code_i),
   .src_a_i      (src_a_i),
   .src_b_i      (src_b_i),
   .fpu_en_i     (fpu_en_i),
   .aux_rd_i     (aux_rd_i),
   .aux_wr_i     (aux_wr_i),
   .aux_num_i    (aux_num_i),
   .aux_wdata_i  (aux_wdata_i),
   .res_valid_o  (res_valid_o),
   .res_data_o   (res_data_o),
   .aux_rvalid_o (aux_rvalid_o),
   .aux_rdata_o  (aux_rdata_o),
   .trap_fpu_o   (trap_fpu_o),
   .trap_ill_o   (trap_ill_o),
   .gsr_q        (gsr_q)
);

// File: tb/byte_align_unit_test.sv
`timescale 1ns/1ps
module byte_align_unit_test;

   localparam logic [8:0] C_ALIGN = 9'h018;
   localparam logic [8:0] C_LE    = 9'h01a;
   localparam logic [8:0] C_FAL   = 9'h048;
   localparam logic [4:0] N_GSR   = 5'h13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid_i = 1'b0;
   logic [8:0]  op_code_i = '0;
   logic [63:0] src_a_i = '0, src_b_i = '0;
   logic        fpu_en_i = 1'b1;
   logic        aux_rd_i = 1'b0, aux_wr_i = 1'b0;
   logic [4:0]  aux_num_i = '0;
   logic [63:0] aux_wdata_i = '0;
   logic        res_valid_o, aux_rvalid_o, trap_fpu_o, trap_ill_o;
   logic [63:0] res_data_o, aux_rdata_o;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   byte_align_unit uut (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
      .src_a_i(src_a_i), .src_b_i(src_b_i), .fpu_en_i(fpu_en_i),
      .aux_rd_i(aux_rd_i), .aux_wr_i(aux_wr_i), .aux_num_i(aux_num_i),
      .aux_wdata_i(aux_wdata_i), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
      .aux_rvalid_o(aux_rvalid_o), .aux_rdata_o(aux_rdata_o),
      .trap_fpu_o(trap_fpu_o), .trap_ill_o(trap_ill_o)
   );

   // captured outputs of the last step
   logic        g_rv, g_av, g_tf, g_ti;
   logic [63:0] g_rd, g_ad;

   typedef struct packed {
      logic        is_fal;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] pre;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{1'b0, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_0005, 64'hFFFF_0000_1234_5678},
      '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0000},
      '{1'b0, 64'h1234_5678_9ABC_DEF3, 64'h0000_0000_0000_0004, 64'hA5A5_A5A5_A5A5_A5A5},
      '{1'b0, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_0007},
      '{1'b1, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 64'h0000_0000_0000_0001},
      '{1'b1, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 64'hFFFF_FFFF_0000_0003},
      '{1'b1, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 64'h5A00_0000_0000_0007},
      '{1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0004},
      '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0005},
      '{1'b1, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002}
   };

   // byte-wise reference: result byte j (most significant first) is byte j+k of {a,b}
   function automatic logic [63:0] ref_fal(input logic [63:0] a, input logic [63:0] b,
                                           input int k);
      logic [127:0] cat;
      logic [63:0]  r;
      cat = {a, b};
      for (int j = 0; j < 8; j++) r[63-8*j -: 8] = cat[127-8*(j+k) -: 8];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic ov, input logic [8:0] oc, input logic [63:0] a,
                       input logic [63:0] b, input logic rd, input logic wr,
                       input logic [4:0] num, input logic [63:0] wd, input logic fe);
      op_valid_i = ov; op_code_i = oc; src_a_i = a; src_b_i = b;
      aux_rd_i = rd; aux_wr_i = wr; aux_num_i = num; aux_wdata_i = wd; fpu_en_i = fe;
      @(negedge clk);
      g_rv = res_valid_o; g_rd = res_data_o; g_av = aux_rvalid_o; g_ad = aux_rdata_o;
      g_tf = trap_fpu_o; g_ti = trap_ill_o;
      op_valid_i = 0; aux_rd_i = 0; aux_wr_i = 0; fpu_en_i = 1;
   endtask

   task automatic op(input logic [8:0] oc, input logic [63:0] a, input logic [63:0] b,
                     input logic fe);
      step(1, oc, a, b, 0, 0, 5'h0, 64'h0, fe);
   endtask

   task automatic gsr_wr(input logic [63:0] v);
      step(0, 9'h0, 64'h0, 64'h0, 0, 1, N_GSR, v, 1);
   endtask

   task automatic gsr_rd(output logic [63:0] v);
      step(0, 9'h0, 64'h0, 64'h0, 1, 0, N_GSR, 64'h0, 1);
      v = g_ad;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [63:0] rb, sum, expv;
      repeat (3) @(negedge clk);
      // R11: outputs at reset
      check(!res_valid_o && !aux_rvalid_o && !trap_fpu_o && !trap_ill_o &&
            res_data_o == 0 && aux_rdata_o == 0, "R11 outputs in reset",
            {res_data_o[59:0], res_valid_o, aux_rvalid_o, trap_fpu_o, trap_ill_o}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      gsr_rd(rb);
      check(g_av && rb == 0, "R11 status reads zero after reset", rb, 64'h0);

      // table walk
      for (int i = 0; i < 10; i++) begin
         gsr_wr(VEC[i].pre);
         if (VEC[i].is_fal) begin
            op(C_FAL, VEC[i].a, VEC[i].b, 1);
            expv = ref_fal(VEC[i].a, VEC[i].b, int'(VEC[i].pre[2:0]));
            check(g_rv && g_rd == expv, "R3 funnel result", g_rd, expv);
         end else begin
            op(C_ALIGN, VEC[i].a, VEC[i].b, 1);
            sum  = VEC[i].a + VEC[i].b;
            expv = {sum[63:3], 3'b000};
            check(g_rv && g_rd == expv, "R1 aligned sum", g_rd, expv);
            gsr_rd(rb);
            expv = {VEC[i].pre[63:3], sum[2:0]};
            check(rb == expv, "R2 offset recorded, upper bits kept", rb, expv);
         end
      end

      // R1: result strobe lasts one cycle
      op(C_ALIGN, 64'h40, 64'h3, 1);
      step(0, 9'h0, 64'h0, 64'h0, 0, 0, 5'h0, 64'h0, 1);
      check(!g_rv, "R1 single-cycle result strobe", {63'h0, g_rv}, 64'h0);

      // R4: zero offset returns src_a exactly
      gsr_wr(64'hFFFF_FFFF_FFFF_FFF8);
      op(C_FAL, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 1);
      check(g_rv && g_rd == 64'h0123_4567_89AB_CDEF, "R4 zero offset", g_rd,
            64'h0123_4567_89AB_CDEF);

      // R5: little-endian variant does nothing
      gsr_wr(64'h1111_2222_3333_4445);
      op(C_LE, 64'h7, 64'h7, 1);
      check(!g_rv && !g_ti && !g_tf, "R5 no result or trap",
            {61'h0, g_rv, g_ti, g_tf}, 64'h0);
      gsr_rd(rb);
      check(rb == 64'h1111_2222_3333_4445, "R5 status unchanged", rb, 64'h1111_2222_3333_4445);

      // R6: illegal codes
      op(9'h019, 64'h5, 64'h6, 1);
      check(g_ti && !g_rv && !g_tf, "R6 illegal 0x019 traps",
            {61'h0, g_ti, g_rv, g_tf}, 64'h4);
      op(9'h000, 64'h5, 64'h6, 1);
      check(g_ti && !g_rv, "R6 illegal 0x000 traps", {62'h0, g_ti, g_rv}, 64'h2);
      gsr_rd(rb);
      check(rb == 64'h1111_2222_3333_4445, "R6 status unchanged", rb, 64'h1111_2222_3333_4445);

      // R7: unit disabled
      op(C_ALIGN, 64'h1, 64'h2, 0);
      check(g_tf && !g_rv && !g_ti, "R7 disabled op traps",
            {61'h0, g_tf, g_rv, g_ti}, 64'h4);
      step(0, 9'h0, 64'h0, 64'h0, 0, 1, N_GSR, 64'hDEAD, 0);
      check(g_tf, "R7 disabled write traps", {63'h0, g_tf}, 64'h1);
      step(0, 9'h0, 64'h0, 64'h0, 1, 0, N_GSR, 64'h0, 0);
      check(g_tf && !g_av, "R7 disabled read traps, no response",
            {62'h0, g_tf, g_av}, 64'h2);
      gsr_rd(rb);
      check(rb == 64'h1111_2222_3333_4445, "R7 status unchanged", rb, 64'h1111_2222_3333_4445);

      // R8: full write then read; read in same cycle as write returns old value
      gsr_wr(64'hCAFE_BABE_0BAD_F00D);
      gsr_rd(rb);
      check(g_av && rb == 64'hCAFE_BABE_0BAD_F00D, "R8 full-width write/read", rb,
            64'hCAFE_BABE_0BAD_F00D);
      step(0, 9'h0, 64'h0, 64'h0, 1, 1, N_GSR, 64'h0000_0000_0000_0002, 1);
      check(g_av && g_ad == 64'hCAFE_BABE_0BAD_F00D, "R8 read sees pre-write value", g_ad,
            64'hCAFE_BABE_0BAD_F00D);

      // R9: explicit write and align update in the same cycle
      step(1, C_ALIGN, 64'h100, 64'h5, 0, 1, N_GSR, 64'h7777_6666_5555_4440, 1);
      check(g_rv && g_rd == 64'h100, "R9 align result still returned", g_rd, 64'h100);
      gsr_rd(rb);
      check(rb == 64'h7777_6666_5555_4440, "R9 write wins over offset update", rb,
            64'h7777_6666_5555_4440);

      // R10: other register numbers ignored
      step(0, 9'h0, 64'h0, 64'h0, 0, 1, 5'h12, 64'h0, 1);
      step(0, 9'h0, 64'h0, 64'h0, 1, 0, 5'h14, 64'h0, 1);
      check(!g_av, "R10 no response to other number", {63'h0, g_av}, 64'h0);
      gsr_rd(rb);
      check(rb == 64'h7777_6666_5555_4440, "R10 status unchanged", rb, 64'h7777_6666_5555_4440);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule